// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers every interrupt source of an eight-stream audio host controller. It produces one 32-bit interrupt status word and one interrupt output. The sources are:

- the response-ring flags (the "responses ready" flag and the overrun flag);
- the codec state-change bits, qualified by a wake-enable mask;
- the buffer-completion flag held in each stream's control word;
- the interrupt control word, which holds one enable per status bit plus a global enable.

The status word is rebuilt from its sources on every clock. A source that software clears therefore disappears from the word one cycle later. No status storage is kept here.

The output has two modes. In pin mode, a level-sensitive line carries the registered interrupt level. In message mode, the line stays low. Instead, a one-cycle message pulse is issued each time the level goes from 0 to 1. A level that stays high therefore sends only one message. Register decoding, write-one-to-clear handling of the source registers and the DMA engines belong to neighbouring blocks.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the status word, the interrupt line and the message pulse are all zero.
- R2: Status bit 30 (controller summary) is 1 in any of these cases: the response-ready flag is set, the response-overrun flag is set, or some codec state-change bit is set together with the same bit of the wake-enable mask.
- R3: A codec state-change bit whose wake-enable bit is clear has no effect on status bit 30.
- R4: Status bit i (for i below the stream count) equals bit 26 of stream i's control word. All other bits of a control word have no effect on the status word.
- R5: Status bit 31 (global) is 1 exactly when some status bit among 30:0 is also set in the interrupt control word.
- R6: Only the control bits in the mask 0xC00000FF take effect. Bits 29:8 of the control word never influence the status word or the outputs.
- R7: In pin mode, the interrupt line is 1 only when status bit 31 and control bit 31 (global enable) are both 1.
- R8: In message mode, the interrupt line stays 0. The message pulse is high for exactly one cycle after each 0-to-1 transition of the interrupt level, and is not repeated while the level stays high.
- R9: Status bits 29 down to the stream count always read 0.
- R10: The status word and the interrupt level reflect their inputs after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_mode | input | 1 | 1 selects message-pulse signalling, 0 selects the level line |
| resp_done_flag | input | 1 | Response-ring "responses ready" flag |
| resp_ovr_flag | input | 1 | Response-ring overrun flag |
| codec_chg_sts | input | NCODEC | Codec state-change status bits |
| wake_mask | input | NCODEC | Wake-enable mask for the codec bits |
| stream_ctl | input | NSTREAM*CTL_W | Stream control words, stream i in bits [i*CTL_W +: CTL_W] |
| irq_ctrl | input | 32 | Interrupt control word (per-bit enables, global enable in bit 31) |
| irq_status | output | 32 | Interrupt status word |
| irq_line | output | 1 | Level interrupt output (pin mode) |
| msg_pulse | output | 1 | One-cycle message request (message mode) |

## Verification
The bench builds the block with its defaults: eight streams, fifteen codec bits and 32-bit stream control words. With these values the enable mask is exactly 0xC00000FF. This puts the reserved gap of bits 29:8 within reach of a check, so the bench can test that it stays zero even when its control bits are all ones. Setting every bit of a stream word except the completion bit shows that bit 26 is the only one decoded. Toggling message mode while the level is held high, then dropping and raising the level again, covers the single-pulse and re-arm behaviour.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int STS_W    = 32;
  localparam int GLB_BIT  = 31;
  localparam int CTRL_BIT = 30;

  // Enable mask: global, controller summary, and one bit per stream.
  function automatic logic [STS_W-1:0] ctl_keep_mask(input int nstream);
    logic [STS_W-1:0] m;
    m = '0;
    m[GLB_BIT]  = 1'b1;
    m[CTRL_BIT] = 1'b1;
    for (int i = 0; i < nstream; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqagg_src.sv
module irqagg_src
  import irqagg_pkg::*;
#(
  parameter int NSTREAM  = 8,
  parameter int NCODEC   = 15,
  parameter int CTL_W    = 32,
  parameter int DONE_BIT = 26
) (
  input  logic                     resp_done_flag,
  input  logic                     resp_ovr_flag,
  input  logic [NCODEC-1:0]        codec_chg_sts,
  input  logic [NCODEC-1:0]        wake_mask,
  input  logic [NSTREAM*CTL_W-1:0] stream_ctl,
  input  logic [STS_W-1:0]         ctl_eff,
  output logic [NSTREAM-1:0]       strm_done,
  output logic                     ctrl_hit,
  output logic [STS_W-1:0]         sts_next
);
  localparam int SUM_W = STS_W - 1;

  function automatic logic [NSTREAM-1:0] pick_done(input logic [NSTREAM*CTL_W-1:0] w);
    logic [NSTREAM-1:0] r;
    for (int i = 0; i < NSTREAM; i++) r[i] = w[i*CTL_W + DONE_BIT];
    return r;
  endfunction

  function automatic logic summary(input logic a, input logic b,
                                   input logic [NCODEC-1:0] chg,
                                   input logic [NCODEC-1:0] en);
    return a | b | (|(chg & en));
  endfunction

  function automatic logic global_of(input logic [SUM_W-1:0] s,
                                     input logic [SUM_W-1:0] en);
    return |(s & en);
  endfunction

  assign strm_done = pick_done(stream_ctl);
  assign ctrl_hit  = summary(resp_done_flag, resp_ovr_flag, codec_chg_sts, wake_mask);

  always_comb begin
    sts_next                = '0;
    sts_next[NSTREAM-1:0]   = strm_done;
    sts_next[CTRL_BIT]      = ctrl_hit;
    sts_next[GLB_BIT]       = global_of(sts_next[SUM_W-1:0], ctl_eff[SUM_W-1:0]);
  end
endmodule

// File: rtl/irqagg_out.sv
module irqagg_out
  import irqagg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_mode,
  input  logic [STS_W-1:0] sts_next,
  input  logic [STS_W-1:0] ctl_eff,
  output logic [STS_W-1:0] sts_q,
  output logic             lvl_q,
  output logic             lvl_rise,
  output logic             irq_line,
  output logic             msg_pulse
);
  logic lvl_d;
  logic lvl_prev_q;

  assign lvl_d = sts_next[GLB_BIT] & ctl_eff[GLB_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q      <= '0;
      lvl_q      <= 1'b0;
      lvl_prev_q <= 1'b0;
    end else begin
      sts_q      <= sts_next;
      lvl_q      <= lvl_d;
      lvl_prev_q <= lvl_q;
    end
  end

  assign lvl_rise  = lvl_q & ~lvl_prev_q;
  assign irq_line  = ~msg_mode & lvl_q;
  assign msg_pulse = msg_mode & lvl_rise;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NSTREAM  = 8,
  parameter int NCODEC   = 15,
  parameter int CTL_W    = 32,
  parameter int DONE_BIT = 26
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     msg_mode,
  input  logic                     resp_done_flag,
  input  logic                     resp_ovr_flag,
  input  logic [NCODEC-1:0]        codec_chg_sts,
  input  logic [NCODEC-1:0]        wake_mask,
  input  logic [NSTREAM*CTL_W-1:0] stream_ctl,
  input  logic [31:0]              irq_ctrl,
  output logic [31:0]              irq_status,
  output logic                     irq_line,
  output logic                     msg_pulse
);
  localparam logic [STS_W-1:0] KEEP = ctl_keep_mask(NSTREAM);

  logic [STS_W-1:0]   ctl_eff;
  logic [STS_W-1:0]   sts_next;
  logic [NSTREAM-1:0] strm_done;
  logic               ctrl_hit;
  logic               lvl_q;
  logic               lvl_rise;

  assign ctl_eff = irq_ctrl & KEEP;

  irqagg_src #(
    .NSTREAM(NSTREAM), .NCODEC(NCODEC), .CTL_W(CTL_W), .DONE_BIT(DONE_BIT)
  ) u_src (
    .resp_done_flag(resp_done_flag),
    .resp_ovr_flag (resp_ovr_flag),
    .codec_chg_sts (codec_chg_sts),
    .wake_mask     (wake_mask),
    .stream_ctl    (stream_ctl),
    .ctl_eff       (ctl_eff),
    .strm_done     (strm_done),
    .ctrl_hit      (ctrl_hit),
    .sts_next      (sts_next)
  );

  irqagg_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .msg_mode (msg_mode),
    .sts_next (sts_next),
    .ctl_eff  (ctl_eff),
    .sts_q    (irq_status),
    .lvl_q    (lvl_q),
    .lvl_rise (lvl_rise),
    .irq_line (irq_line),
    .msg_pulse(msg_pulse)
  );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int NSTREAM  = 8,
  parameter int NCODEC   = 15,
  parameter int CTL_W    = 32,
  parameter int DONE_BIT = 26
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     msg_mode,
  input logic                     resp_done_flag,
  input logic                     resp_ovr_flag,
  input logic [NCODEC-1:0]        codec_chg_sts,
  input logic [NCODEC-1:0]        wake_mask,
  input logic [NSTREAM*CTL_W-1:0] stream_ctl,
  input logic [31:0]              irq_status,
  input logic                     irq_line,
  input logic                     msg_pulse,
  input logic                     lvl_q,
  input logic                     lvl_rise
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_summary_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_status[30] ==
      $past(resp_done_flag | resp_ovr_flag | (|(codec_chg_sts & wake_mask))));

  p_stream0_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_status[0] == $past(stream_ctl[DONE_BIT]));

  p_line_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line |-> (irq_status[31] && lvl_q));

  p_pulse_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |=> !msg_pulse);

  p_pulse_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |-> (lvl_rise && !$past(lvl_q)));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[29:NSTREAM] == '0);
endmodule

bind irq_aggregator irqagg_chk #(
  .NSTREAM(NSTREAM), .NCODEC(NCODEC), .CTL_W(CTL_W), .DONE_BIT(DONE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode),
  .resp_done_flag(resp_done_flag), .resp_ovr_flag(resp_ovr_flag),
  .codec_chg_sts(codec_chg_sts), .wake_mask(wake_mask),
  .stream_ctl(stream_ctl), .irq_status(irq_status),
  .irq_line(irq_line), .msg_pulse(msg_pulse),
  .lvl_q(lvl_q), .lvl_rise(lvl_rise)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int NS = 8;
  localparam int NC = 15;
  localparam int CW = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           msg_mode = 1'b0;
  logic           rdone = 1'b0, rovr = 1'b0;
  logic [NC-1:0]  chg = '0, wake = '0;
  logic [NS*CW-1:0] sctl = '0;
  logic [31:0]    ctl = '0;
  logic [31:0]    status;
  logic           line, pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode),
    .resp_done_flag(rdone), .resp_ovr_flag(rovr),
    .codec_chg_sts(chg), .wake_mask(wake), .stream_ctl(sctl),
    .irq_ctrl(ctl), .irq_status(status), .irq_line(line), .msg_pulse(pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent status model from the requirements.
  function automatic logic [31:0] model();
    logic [31:0] s;
    logic any;
    s = 32'h0;
    s[30] = rdone || rovr;
    for (int k = 0; k < NC; k++) if (chg[k] && wake[k]) s[30] = 1'b1;
    for (int j = 0; j < NS; j++) s[j] = sctl[j*CW + 26];
    any = 1'b0;
    for (int b = 0; b < 31; b++)
      if (s[b] && ctl[b] && (b == 30 || b < NS)) any = 1'b1;
    s[31] = any;
    return s;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_src();
    rdone = 0; rovr = 0; chg = '0; wake = '0; sctl = '0; ctl = '0; msg_mode = 0;
    step(); step();
  endtask

  task automatic apply(input string req);
    logic [31:0] e;
    e = model();
    step();
    chk(req, status, e);
    chk(req, {31'b0, line}, {31'b0, (!msg_mode && e[31] && ctl[31])});
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h0);
    chk("R1 line", {31'b0, line}, 32'h0);
    chk("R1 pulse", {31'b0, pulse}, 32'h0);
  endtask

  task automatic t_summary();
    clear_src();
    rdone = 1; apply("R2 resp done");
    chk("R2 bit30", {31'b0, status[30]}, 32'h1);
    rdone = 0; rovr = 1; apply("R2 overrun");
    rovr = 0; chg[3] = 1; wake[3] = 1; apply("R2 codec+wake");
    chk("R2 codec bit30", {31'b0, status[30]}, 32'h1);
    wake = 15'h7FF7; apply("R3 unmasked codec");
    chk("R3 bit30 clear", {31'b0, status[30]}, 32'h0);
  endtask

  task automatic t_streams();
    clear_src();
    sctl[5*CW + 26] = 1'b1; apply("R4 stream5");
    chk("R4 bit5", status, 32'h0000_0020);
    sctl = '1; sctl[5*CW + 26] = 1'b0; sctl[0*CW + 26] = 1'b0;
    for (int j = 1; j < NS; j++) if (j != 5) sctl[j*CW + 26] = 1'b0;
    apply("R4 other bits ignored");
    chk("R4 zero status", status, 32'h0);
  endtask

  task automatic t_global();
    clear_src();
    sctl[2*CW + 26] = 1'b1; ctl = 32'h0000_0004; apply("R5 enabled bit");
    chk("R5 bit31", {31'b0, status[31]}, 32'h1);
    ctl = 32'h0000_0008; apply("R5 other enable");
    chk("R5 bit31 clear", {31'b0, status[31]}, 32'h0);
    ctl = 32'h3FFF_FF00; rdone = 1; sctl = '1; apply("R6 reserved ctl");
    chk("R6 no global", {31'b0, status[31]}, 32'h0);
    chk("R9 gap zero", {2'b0, status[29:8]}, 32'h0);
  endtask

  task automatic t_pin();
    clear_src();
    sctl[2*CW + 26] = 1'b1; ctl = 32'h8000_0004; apply("R7 pin high");
    chk("R7 line", {31'b0, line}, 32'h1);
    ctl = 32'h0000_0004; apply("R7 no global enable");
    chk("R7 line low", {31'b0, line}, 32'h0);
  endtask

  task automatic t_msg();
    clear_src();
    msg_mode = 1; ctl = 32'hC000_0000; rovr = 1;
    step();
    chk("R8 first pulse", {31'b0, pulse}, 32'h1);
    chk("R8 line low", {31'b0, line}, 32'h0);
    step();
    chk("R8 no repeat", {31'b0, pulse}, 32'h0);
    step();
    chk("R8 still quiet", {31'b0, pulse}, 32'h0);
    rovr = 0; step(); step();
    chk("R8 low level", {31'b0, pulse}, 32'h0);
    rovr = 1; step();
    chk("R8 re-armed pulse", {31'b0, pulse}, 32'h1);
  endtask

  task automatic t_latency();
    clear_src();
    ctl = 32'h8000_0001; sctl[26] = 1'b1;
    #1;
    chk("R10 before edge", status, 32'h0);
    chk("R10 line before", {31'b0, line}, 32'h0);
    step();
    chk("R10 after edge", status, 32'h8000_0001);
    chk("R10 line after", {31'b0, line}, 32'h1);
    sctl[26] = 1'b0; #1;
    chk("R10 hold", status, 32'h8000_0001);
    step();
    chk("R10 cleared", status, 32'h0);
  endtask

  initial begin
    #1;
    chk("R1 during reset", status, 32'h0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_summary();
    t_streams();
    t_global();
    t_pin();
    t_msg();
    t_latency();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule